// File: doc/BRIEF.md
# Partitioned Audio Channel FIFO

This block is a small staging buffer that sits between a DMA engine and an audio streaming fabric. A single storage array is split into one region per channel. Each region's start address and length are set by configuration inputs, and each region works as its own circular queue.

A channel runs in one of two directions:
- **Playback** channels take words from the DMA and hand them to the fabric. A playback channel holds its output back until its fill level reaches a programmed threshold. Once output has begun, it keeps draining until the region is empty. The threshold gate then closes again.
- **Capture** channels accept fabric words whenever there is room. The DMA can read those words back at once, with no gating.

The DMA side is a single shared port with a channel select. The only feedback the DMA receives is a one-cycle event pulse per channel for every word that moves on the fabric side. From those pulses the DMA tracks each region's occupancy itself. A sticky per-channel overrun flag reports a DMA write that found its region full. A sticky underrun flag reports a DMA read that found its region empty.

Top module: `shared_slice_fifo`

## Requirements
- R1: While reset is low, and after it is released, every region is empty and `overrun` and `underrun` are zero. `fabOutValid` and `fabEvent` are zero. `fabInReady` is high exactly on capture channels (`cfgPlay` bit 0).
- R2: A DMA read (`dmaRdEn`, `dmaCh`) of a non-empty capture region returns its oldest word on `dmaRdData` in the same cycle. A fabric word accepted on a clock edge can be read from the next cycle onward. When no read succeeds, `dmaRdData` is zero.
- R3: `fabInReady[c]` is high only for a capture channel whose region holds fewer words than its configured size.
- R4: `fabOutValid[c]` is high only for a playback channel (`cfgPlay[c]`=1). It stays low until the fill reaches `cfgThresh[c]`, and rises in the cycle after the DMA write that brings the fill to the threshold. With a threshold of 16, two 8-word DMA bursts must land before it rises.
- R5: Once a playback channel has started draining, `fabOutValid` stays high while the region is non-empty, even when the fill is below the threshold. After the region empties, the gate closes again and fill must again reach the threshold.
- R6: Words leave each region on the fabric side in the order the DMA wrote them.
- R7: `fabEvent[c]` is high in exactly those cycles with a fabric handshake on channel c: a playback output or a capture input. Each such cycle is one word. Pulses on different channels are independent.
- R8: A DMA write to a full playback region is dropped and sets `overrun[c]`. The flag stays set until reset.
- R9: A DMA read of an empty capture region returns zero, changes no state and sets `underrun[c]`. The flag stays set until reset.
- R10: A DMA write to a capture channel and a DMA read of a playback channel are ignored. The region's contents and order are unchanged, and `dmaRdData` is zero.
- R11: Each region wraps within its own base and size. Traffic on one channel never alters or exposes another channel's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPlay | input | NUM_CH | Per-channel direction: 1 = playback, 0 = capture |
| cfgBase | input | NUM_CH*ADDR_W | Per-channel region start address |
| cfgSize | input | NUM_CH*CNT_W | Per-channel region length in words |
| cfgThresh | input | NUM_CH*CNT_W | Per-channel playback start threshold |
| dmaWrEn | input | 1 | DMA write strobe |
| dmaRdEn | input | 1 | DMA read strobe |
| dmaCh | input | CH_W | Channel addressed by the DMA |
| dmaWrData | input | DATA_W | DMA write word |
| dmaRdData | output | DATA_W | DMA read word, zero when no read succeeds |
| fabInValid | input | NUM_CH | Capture word offered by the fabric |
| fabInData | input | NUM_CH*DATA_W | Capture words, channel c at bits c*DATA_W |
| fabInReady | output | NUM_CH | Capture region can accept a word |
| fabOutValid | output | NUM_CH | Playback word available |
| fabOutData | output | NUM_CH*DATA_W | Playback words, channel c at bits c*DATA_W |
| fabOutReady | input | NUM_CH | Fabric takes the playback word |
| fabEvent | output | NUM_CH | One pulse per fabric-side word |
| overrun | output | NUM_CH | Sticky full-write flag |
| underrun | output | NUM_CH | Sticky empty-read flag |

## Verification
The properties assume the following about the inputs:
- The configuration stays constant from reset onward.
- Regions do not overlap and each fits inside the array.
- Every size is at least one and every threshold is no larger than its size.
- The DMA never asserts read and write in the same cycle.

The stimulus sets one fixed, legal layout before reset is released and never changes it. It generates DMA operations as a single choice per cycle between write, read or idle, so the two strobes are never raised together.

// File: rtl/shared_slice_fifo_pkg.sv
package shared_slice_fifo_pkg;

  // Per-channel strobes from control to datapath for one cycle.
  typedef struct packed {
    logic dmaPush;
    logic dmaPop;
    logic fabPush;
    logic fabPop;
  } chanStrobe_t;

endpackage

// File: rtl/shared_slice_fifo_ctrl.sv
module shared_slice_fifo_ctrl
  import shared_slice_fifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int CH_W   = 2,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         cfgPlay,
  input  logic [NUM_CH*ADDR_W-1:0]  cfgBase,
  input  logic [NUM_CH*CNT_W-1:0]   cfgSize,
  input  logic [NUM_CH*CNT_W-1:0]   cfgThresh,
  input  logic                      dmaWrEn,
  input  logic                      dmaRdEn,
  input  logic [CH_W-1:0]           dmaCh,
  input  logic [NUM_CH-1:0]         fabInValid,
  input  logic [NUM_CH-1:0]         fabOutReady,
  output chanStrobe_t [NUM_CH-1:0]  strobe,
  output logic [NUM_CH-1:0][ADDR_W-1:0] wrAddr,
  output logic [NUM_CH-1:0][ADDR_W-1:0] rdAddr,
  output logic [NUM_CH-1:0]         fabInReady,
  output logic [NUM_CH-1:0]         fabOutValid,
  output logic [NUM_CH-1:0]         fabEvent,
  output logic [NUM_CH-1:0]         overrun,
  output logic [NUM_CH-1:0]         underrun
);

  // Advance an offset around a region of sz words.
  function automatic logic [ADDR_W-1:0] bumpOff(input logic [ADDR_W-1:0] off,
                                                input logic [CNT_W-1:0] sz);
    return ({1'b0, off} == sz - CNT_W'(1)) ? '0 : off + ADDR_W'(1);
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [CNT_W-1:0]  count, countNext, size, thresh;
    logic [ADDR_W-1:0] wrOff, rdOff, base;
    logic              draining, drainNext;
    logic              isPlay, full, empty, dmaHit;
    logic              dmaPush, dmaPop, fabPush, fabPop, push, pop;
    logic              ovfReg, udfReg, outValid, inReady;

    assign isPlay = cfgPlay[c];
    assign base   = cfgBase[c*ADDR_W +: ADDR_W];
    assign size   = cfgSize[c*CNT_W +: CNT_W];
    assign thresh = cfgThresh[c*CNT_W +: CNT_W];
    assign full   = (count == size);
    assign empty  = (count == '0);
    assign dmaHit = (dmaCh == CH_W'(c));

    // DMA side: write only to playback, read only from capture.
    assign dmaPush = dmaWrEn && dmaHit && isPlay && !full;
    assign dmaPop  = dmaRdEn && dmaHit && !isPlay && !empty;

    // Fabric side handshakes.
    assign outValid = isPlay && draining && !empty;
    assign inReady  = !isPlay && !full;
    assign fabPop   = outValid && fabOutReady[c];
    assign fabPush  = inReady && fabInValid[c];

    assign push = dmaPush | fabPush;
    assign pop  = dmaPop | fabPop;
    assign countNext = count + CNT_W'(push) - CNT_W'(pop);

    // Threshold gate: opens at threshold, closes on empty.
    always_comb begin
      if (!isPlay)       drainNext = 1'b0;
      else if (draining) drainNext = (countNext != '0);
      else               drainNext = (countNext >= thresh);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        count    <= '0;
        wrOff    <= '0;
        rdOff    <= '0;
        draining <= 1'b0;
        ovfReg   <= 1'b0;
        udfReg   <= 1'b0;
      end else begin
        count    <= countNext;
        draining <= drainNext;
        if (push) wrOff <= bumpOff(wrOff, size);
        if (pop)  rdOff <= bumpOff(rdOff, size);
        if (dmaWrEn && dmaHit && isPlay && full)   ovfReg <= 1'b1;
        if (dmaRdEn && dmaHit && !isPlay && empty) udfReg <= 1'b1;
      end
    end

    assign strobe[c].dmaPush = dmaPush;
    assign strobe[c].dmaPop  = dmaPop;
    assign strobe[c].fabPush = fabPush;
    assign strobe[c].fabPop  = fabPop;
    assign wrAddr[c]      = base + wrOff;
    assign rdAddr[c]      = base + rdOff;
    assign fabOutValid[c] = outValid;
    assign fabInReady[c]  = inReady;
    assign fabEvent[c]    = fabPop | fabPush;
    assign overrun[c]     = ovfReg;
    assign underrun[c]    = udfReg;
  end

endmodule

// File: rtl/shared_slice_fifo_dp.sv
module shared_slice_fifo_dp
  import shared_slice_fifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  chanStrobe_t [NUM_CH-1:0]      strobe,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] wrAddr,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0]             dmaWrData,
  input  logic [NUM_CH*DATA_W-1:0]      fabInData,
  output logic [DATA_W-1:0]             dmaRdData,
  output logic [NUM_CH*DATA_W-1:0]      fabOutData
);

  logic [DATA_W-1:0] store [DEPTH];

  // Regions never overlap, so per-channel writes never collide.
  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobe[c].dmaPush)
        store[wrAddr[c]] <= dmaWrData;
      else if (strobe[c].fabPush)
        store[wrAddr[c]] <= fabInData[c*DATA_W +: DATA_W];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign fabOutData[c*DATA_W +: DATA_W] = store[rdAddr[c]];
  end

  // At most one channel pops on the DMA port per cycle.
  always_comb begin
    dmaRdData = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (strobe[c].dmaPop) dmaRdData = store[rdAddr[c]];
  end

endmodule

// File: rtl/shared_slice_fifo.sv
module shared_slice_fifo
  import shared_slice_fifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        cfgPlay,
  input  logic [NUM_CH*ADDR_W-1:0] cfgBase,
  input  logic [NUM_CH*CNT_W-1:0]  cfgSize,
  input  logic [NUM_CH*CNT_W-1:0]  cfgThresh,
  input  logic                     dmaWrEn,
  input  logic                     dmaRdEn,
  input  logic [CH_W-1:0]          dmaCh,
  input  logic [DATA_W-1:0]        dmaWrData,
  output logic [DATA_W-1:0]        dmaRdData,
  input  logic [NUM_CH-1:0]        fabInValid,
  input  logic [NUM_CH*DATA_W-1:0] fabInData,
  output logic [NUM_CH-1:0]        fabInReady,
  output logic [NUM_CH-1:0]        fabOutValid,
  output logic [NUM_CH*DATA_W-1:0] fabOutData,
  input  logic [NUM_CH-1:0]        fabOutReady,
  output logic [NUM_CH-1:0]        fabEvent,
  output logic [NUM_CH-1:0]        overrun,
  output logic [NUM_CH-1:0]        underrun
);

  chanStrobe_t [NUM_CH-1:0]      strobe;
  logic [NUM_CH-1:0][ADDR_W-1:0] wrAddr;
  logic [NUM_CH-1:0][ADDR_W-1:0] rdAddr;

  shared_slice_fifo_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgPlay(cfgPlay), .cfgBase(cfgBase), .cfgSize(cfgSize), .cfgThresh(cfgThresh),
    .dmaWrEn(dmaWrEn), .dmaRdEn(dmaRdEn), .dmaCh(dmaCh),
    .fabInValid(fabInValid), .fabOutReady(fabOutReady),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fabInReady(fabInReady), .fabOutValid(fabOutValid), .fabEvent(fabEvent),
    .overrun(overrun), .underrun(underrun)
  );

  shared_slice_fifo_dp #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dmaWrData(dmaWrData), .fabInData(fabInData),
    .dmaRdData(dmaRdData), .fabOutData(fabOutData)
  );

endmodule

// File: rtl/shared_slice_fifo_chk.sv
module shared_slice_fifo_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] cfgPlay,
  input logic              dmaRdEn,
  input logic [DATA_W-1:0] dmaRdData,
  input logic [NUM_CH-1:0] fabInValid,
  input logic [NUM_CH-1:0] fabInReady,
  input logic [NUM_CH-1:0] fabOutValid,
  input logic [NUM_CH-1:0] fabOutReady,
  input logic [NUM_CH-1:0] fabEvent,
  input logic [NUM_CH-1:0] overrun,
  input logic [NUM_CH-1:0] underrun
);

  p_out_play_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((fabOutValid & ~cfgPlay) == '0));

  p_in_capture_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((fabInReady & cfgPlay) == '0));

  p_event_handshake_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fabEvent == ((fabOutValid & fabOutReady) | (fabInValid & fabInReady))));

  p_valid_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((($past(fabOutValid) & ~$past(fabOutReady))) & ~fabOutValid) == '0));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((overrun & $past(overrun)) == $past(overrun)));

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((underrun & $past(underrun)) == $past(underrun)));

  p_idle_read_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dmaRdEn |-> (dmaRdData == '0));

endmodule

bind shared_slice_fifo shared_slice_fifo_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgPlay(cfgPlay), .dmaRdEn(dmaRdEn), .dmaRdData(dmaRdData),
  .fabInValid(fabInValid), .fabInReady(fabInReady), .fabOutValid(fabOutValid),
  .fabOutReady(fabOutReady), .fabEvent(fabEvent), .overrun(overrun), .underrun(underrun)
);

// File: tb/shared_slice_fifo_test.sv
`timescale 1ns/1ps
module shared_slice_fifo_test;
  localparam int NC = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0]    cfgPlay = 4'b0101;
  logic [NC*6-1:0]  cfgBase;
  logic [NC*7-1:0]  cfgSize, cfgThresh;
  logic dmaWrEn = 0, dmaRdEn = 0;
  logic [1:0] dmaCh = 0;
  logic [DW-1:0] dmaWrData = 0, dmaRdData;
  logic [NC-1:0] fabInValid = 0, fabInReady, fabOutValid, fabOutReady = 0;
  logic [NC-1:0] fabEvent, overrun, underrun;
  logic [NC*DW-1:0] fabInData = 0, fabOutData;

  int checks = 0, failures = 0, ch2Out = 0;
  bit finished = 0;

  int cBase[NC]  = '{0, 20, 28, 34};
  int cSize[NC]  = '{20, 8, 6, 5};
  int cThr[NC]   = '{16, 0, 3, 0};

  logic [DW-1:0] q [NC][$];
  bit mDrain[NC], mOvf[NC], mUdf[NC];

  shared_slice_fifo uut (
    .clk(clk), .rstN(rstN), .cfgPlay(cfgPlay), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgThresh(cfgThresh), .dmaWrEn(dmaWrEn), .dmaRdEn(dmaRdEn), .dmaCh(dmaCh),
    .dmaWrData(dmaWrData), .dmaRdData(dmaRdData), .fabInValid(fabInValid),
    .fabInData(fabInData), .fabInReady(fabInReady), .fabOutValid(fabOutValid),
    .fabOutData(fabOutData), .fabOutReady(fabOutReady), .fabEvent(fabEvent),
    .overrun(overrun), .underrun(underrun)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expValid(int c);
    return cfgPlay[c] && mDrain[c] && (q[c].size() > 0);
  endfunction

  // Compare all outputs against the model for the current inputs.
  task automatic compare();
    for (int c = 0; c < NC; c++) begin
      bit ev = expValid(c);
      bit er = !cfgPlay[c] && (q[c].size() < cSize[c]);
      bit ee = (ev && fabOutReady[c]) || (er && fabInValid[c]);
      chk(fabOutValid[c] == ev, "R4 valid", 32'(fabOutValid[c]), 32'(ev));
      if (ev) chk(fabOutData[c*DW +: DW] == q[c][0], "R6 R11 data", 32'(fabOutData[c*DW +: DW]), 32'(q[c][0]));
      chk(fabInReady[c] == er, "R3 ready", 32'(fabInReady[c]), 32'(er));
      chk(fabEvent[c] == ee, "R7 event", 32'(fabEvent[c]), 32'(ee));
      chk(overrun[c] == mOvf[c], "R8 overrun", 32'(overrun[c]), 32'(mOvf[c]));
      chk(underrun[c] == mUdf[c], "R9 underrun", 32'(underrun[c]), 32'(mUdf[c]));
    end
    begin
      logic [DW-1:0] er;
      er = (dmaRdEn && !cfgPlay[dmaCh] && q[dmaCh].size() > 0) ? q[dmaCh][0] : '0;
      chk(dmaRdData == er, "R2 read data", 32'(dmaRdData), 32'(er));
    end
  endtask

  task automatic update();
    for (int c = 0; c < NC; c++) begin
      bit hitW = dmaWrEn && (int'(dmaCh) == c);
      bit hitR = dmaRdEn && (int'(dmaCh) == c);
      bit full = (q[c].size() == cSize[c]);
      bit empty = (q[c].size() == 0);
      bit pop, push;
      logic [DW-1:0] val;
      if (cfgPlay[c]) begin
        pop  = expValid(c) && fabOutReady[c];
        push = hitW && !full;
        if (hitW && full) mOvf[c] = 1;
        val  = dmaWrData;
      end else begin
        pop  = hitR && !empty;
        if (hitR && empty) mUdf[c] = 1;
        push = fabInValid[c] && !full;
        val  = fabInData[c*DW +: DW];
      end
      if (pop) begin
        void'(q[c].pop_front());
        if (c == 2) ch2Out++;
      end
      if (push) q[c].push_back(val);
      if (cfgPlay[c])
        mDrain[c] = mDrain[c] ? (q[c].size() != 0) : (q[c].size() >= cThr[c]);
    end
  endtask

  task automatic cycle();
    #1 compare();
    @(posedge clk);
    if (rstN) update();
    @(negedge clk);
  endtask

  task automatic dmaWrite(input int c, input logic [DW-1:0] d);
    dmaCh = 2'(c); dmaWrData = d; dmaWrEn = 1;
    cycle();
    dmaWrEn = 0;
  endtask

  task automatic dmaRead(input int c);
    dmaCh = 2'(c); dmaRdEn = 1;
    cycle();
    dmaRdEn = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      cfgBase[c*6 +: 6]   = 6'(cBase[c]);
      cfgSize[c*7 +: 7]   = 7'(cSize[c]);
      cfgThresh[c*7 +: 7] = 7'(cThr[c]);
    end
    @(negedge clk);
    #1;
    chk(fabOutValid == 0, "R1 valid", 32'(fabOutValid), 0);
    chk(fabInReady == 4'b1010, "R1 ready", 32'(fabInReady), 32'hA);
    chk(overrun == 0 && underrun == 0, "R1 flags", 32'({overrun, underrun}), 0);
    chk(fabEvent == 0, "R1 event", 32'(fabEvent), 0);
    cycle(); cycle();
    rstN = 1;
    cycle();

    // Playback threshold: two bursts of 8 against threshold 16.
    for (int i = 0; i < 8; i++) dmaWrite(0, 16'h100 + 16'(i));
    chk(fabOutValid[0] == 0, "R4 gated after one burst", 32'(fabOutValid[0]), 0);
    for (int i = 8; i < 16; i++) dmaWrite(0, 16'h100 + 16'(i));
    chk(fabOutValid[0] == 1, "R4 open after second burst", 32'(fabOutValid[0]), 1);
    fabOutReady[0] = 1;
    repeat (5) cycle();
    fabOutReady[0] = 0;
    chk(fabOutValid[0] == 1, "R5 keeps draining below threshold", 32'(fabOutValid[0]), 1);
    fabOutReady[0] = 1;
    repeat (11) cycle();
    fabOutReady[0] = 0;
    chk(fabOutValid[0] == 0, "R5 empty", 32'(fabOutValid[0]), 0);
    for (int i = 0; i < 5; i++) dmaWrite(0, 16'h300 + 16'(i));
    chk(fabOutValid[0] == 0, "R5 gate re-armed", 32'(fabOutValid[0]), 0);
    for (int i = 5; i < 20; i++) dmaWrite(0, 16'h300 + 16'(i));
    chk(overrun[0] == 0, "R8 no overrun at full", 32'(overrun[0]), 0);
    dmaWrite(0, 16'hDEAD);
    chk(overrun[0] == 1, "R8 overrun set", 32'(overrun[0]), 1);
    fabOutReady[0] = 1;
    repeat (20) cycle();
    fabOutReady[0] = 0;

    // Capture fill, full and readback.
    fabInValid[1] = 1;
    for (int i = 0; i < 10; i++) begin
      fabInData[DW +: DW] = 16'h200 + 16'(i);
      cycle();
    end
    fabInValid[1] = 0;
    chk(fabInReady[1] == 0, "R3 full capture", 32'(fabInReady[1]), 0);
    for (int i = 0; i < 8; i++) dmaRead(1);
    chk(underrun[1] == 0, "R9 no underrun yet", 32'(underrun[1]), 0);
    dmaRead(1);
    chk(underrun[1] == 1, "R9 underrun set", 32'(underrun[1]), 1);

    // Wrong-direction DMA accesses are ignored.
    fabInValid[1] = 1; fabInData[DW +: DW] = 16'h2AA;
    cycle();
    fabInValid[1] = 0;
    dmaWrite(1, 16'hBAD);
    dmaCh = 1; dmaRdEn = 1;
    #1 chk(dmaRdData == 16'h2AA, "R10 capture write ignored", 32'(dmaRdData), 32'h2AA);
    cycle();
    #1 chk(dmaRdData == 16'h0, "R10 capture region holds nothing extra", 32'(dmaRdData), 0);
    cycle();
    dmaRdEn = 0;
    for (int i = 0; i < 16; i++) dmaWrite(0, 16'h400 + 16'(i));
    dmaCh = 0; dmaRdEn = 1;
    #1 chk(dmaRdData == 16'h0, "R10 playback read ignored", 32'(dmaRdData), 0);
    cycle();
    dmaRdEn = 0;
    #1 chk(fabOutData[0 +: DW] == 16'h400, "R10 playback head intact", 32'(fabOutData[0 +: DW]), 32'h400);
    fabOutReady[0] = 1;
    repeat (16) cycle();
    fabOutReady[0] = 0;

    // Mixed traffic on all channels.
    for (int n = 0; n < 800; n++) begin
      int op = $urandom_range(0, 2);
      dmaCh = 2'($urandom_range(0, 3));
      dmaWrData = 16'($urandom);
      dmaWrEn = (op == 1);
      dmaRdEn = (op == 2);
      fabInValid = 4'($urandom);
      fabOutReady = 4'($urandom);
      for (int c = 0; c < NC; c++) fabInData[c*DW +: DW] = 16'($urandom);
      cycle();
    end
    dmaWrEn = 0; dmaRdEn = 0; fabInValid = 0; fabOutReady = 0;
    chk(ch2Out > 12, "R11 region wrapped several times", 32'(ch2Out), 13);
    cycle();
    finished = 1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

endmodule